// File: doc/BRIEF.md
# Tiled Int8 Vector-Matrix Accumulate Engine

This block multiplies a 16-lane signed 8-bit activation vector by a 16x16 signed 8-bit weight tile on every accepted command, producing sixteen dot products. It adds them into one 32-bit-per-lane row of an on-chip accumulator file. The weight tile is held transposed, with output lanes as rows and input lanes as columns. Activation tiles and weight tiles sit in two small write-only-from-outside buffers and are picked by tile index. Accumulator rows sit in a third buffer that the core reads and writes.

A reduction starts with a zeroing command on an accumulator row. It continues with one accumulate command per input-channel tile. The only way a result leaves the block is a store, which narrows each 32-bit lane to its low byte, so the engine accumulates first and quantizes second. Each accumulate command advances a 32-bit operation counter.

Top module: `tile_gemm_core`

## Requirements
- R1: For an accumulate command, output lane j receives the sum over k of act[k]*wgt[j][k], where products are of signed 8-bit values. Activation lane k is in bits [8k+7:8k] of the activation word, and weight element (j,k) is in bits [8(16j+k)+7 : 8(16j+k)] of the weight word.
- R2: An accumulate command adds its vector to the row selected by its accumulator index and does not overwrite it. The activation and weight tiles are selected by their own indices, and rows that are not addressed keep their contents.
- R3: A command with the zero flag set writes zero to every lane of its row, adds no product and is not counted.
- R4: A store returns the low 8 bits of each 32-bit lane (two's-complement wrap, no saturation), with lane j in bits [8j+7:8j] of the output word.
- R5: The store output valid rises exactly one cycle after a store request. The row it returns includes every command accepted up to and including the cycle before the request.
- R6: A command writes its row at the second clock edge after it is accepted. A command that follows one on the same row in the next cycle sees the earlier result through forwarding, so back-to-back accumulation is exact.
- R7: The operation counter increments by one for each accepted non-zeroing command and holds otherwise. It clears on synchronous reset.
- R8: After synchronous reset, the counter reads zero and the store output valid is low.
- R9: A tiled problem of 4 output tiles by 4 input-channel tiles, issued with the input-channel loop outermost, gives the full vector-matrix product in every output row. It advances the counter by exactly 16, which is one per tile operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| act_wr_en | input | 1 | Write strobe for the activation buffer |
| act_wr_idx | input | LOG_INP | Activation tile index to write |
| act_wr_data | input | IN_LANES*DW | Activation tile, lane k at bits [8k+7:8k] |
| wgt_wr_en | input | 1 | Write strobe for the weight buffer |
| wgt_wr_idx | input | LOG_WGT | Weight tile index to write |
| wgt_wr_data | input | OUT_LANES*IN_LANES*DW | Transposed weight tile, element (j,k) at offset 8(16j+k) |
| cmd_valid | input | 1 | Command accepted this cycle |
| cmd_zero | input | 1 | Zero the row instead of accumulating |
| cmd_acc_idx | input | LOG_ACC | Accumulator row to update |
| cmd_act_idx | input | LOG_INP | Activation tile to use |
| cmd_wgt_idx | input | LOG_WGT | Weight tile to use |
| st_valid | input | 1 | Store request |
| st_acc_idx | input | LOG_ACC | Accumulator row to store |
| st_out_valid | output | 1 | Narrowed row valid |
| st_out_data | output | OUT_LANES*DW | Narrowed row, lane j at bits [8j+7:8j] |
| op_count | output | CW | Count of accumulate commands |

## Verification
On every cycle, the assertions check the counter step and hold (R7), the one-cycle store handshake (R5), and that each accepted command reaches the accumulator write port two edges later with its own row index (R6). They also check that a zeroing command writes an all-zero row (R3). The numeric content of rows can only be shown by the bench's scenarios: the dot-product arithmetic and packing, accumulation versus overwrite, the wrap on narrowing, forwarding across back-to-back commands on one row, and the tiled 4x4 reduction. The bench compares each stored row against a product it computes itself.

// File: rtl/tgc_pkg.sv
package tgc_pkg;
  localparam int TGC_DW    = 8;
  localparam int TGC_AW    = 32;
  localparam int TGC_LANES = 16;

  typedef enum logic [1:0] {
    S1_IDLE = 2'd0,
    S1_ZERO = 2'd1,
    S1_MAC  = 2'd2
  } s1_op_e;
endpackage

// File: rtl/tgc_tile_buf.sv
module tgc_tile_buf #(
  parameter int DEPTH_LOG = 4,
  parameter int WIDTH     = 128
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [DEPTH_LOG-1:0] waddr,
  input  logic [WIDTH-1:0]     wdata,
  input  logic [DEPTH_LOG-1:0] raddr,
  output logic [WIDTH-1:0]     rdata
);
  localparam int DEPTH = 1 << DEPTH_LOG;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tgc_mac_array.sv
module tgc_mac_array #(
  parameter int IN_LANES  = 16,
  parameter int OUT_LANES = 16,
  parameter int DW        = 8,
  parameter int AW        = 32
) (
  input  logic [IN_LANES*DW-1:0]           act,
  input  logic [OUT_LANES*IN_LANES*DW-1:0] wgt,
  output logic [OUT_LANES*AW-1:0]          dot
);
  localparam int VEC_W = IN_LANES * DW;

  function automatic logic signed [AW-1:0] lane_dot(
    input logic [VEC_W-1:0] a,
    input logic [VEC_W-1:0] w
  );
    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] ae;
    logic signed [AW-1:0] we_x;
    acc = '0;
    for (int k = 0; k < IN_LANES; k++) begin
      ae   = AW'($signed(a[k*DW +: DW]));
      we_x = AW'($signed(w[k*DW +: DW]));
      acc  = acc + ae * we_x;
    end
    return acc;
  endfunction

  for (genvar j = 0; j < OUT_LANES; j++) begin : g_lane
    assign dot[j*AW +: AW] = lane_dot(act, wgt[j*VEC_W +: VEC_W]);
  end
endmodule

// File: rtl/tgc_acc_file.sv
module tgc_acc_file #(
  parameter int ACC_LOG = 4,
  parameter int ROW_W   = 512
) (
  input  logic               clk,
  input  logic               we,
  input  logic [ACC_LOG-1:0] widx,
  input  logic [ROW_W-1:0]   wdata,
  input  logic [ACC_LOG-1:0] ridx_a,
  output logic [ROW_W-1:0]   rdata_a,
  input  logic [ACC_LOG-1:0] ridx_b,
  output logic [ROW_W-1:0]   rdata_b
);
  localparam int ROWS = 1 << ACC_LOG;

  logic [ROW_W-1:0] rows [ROWS];

  always_ff @(posedge clk) begin
    if (we) rows[widx] <= wdata;
  end

  assign rdata_a = rows[ridx_a];
  assign rdata_b = rows[ridx_b];
endmodule

// File: rtl/tile_gemm_core.sv
module tile_gemm_core
  import tgc_pkg::*;
#(
  parameter int IN_LANES  = TGC_LANES,
  parameter int OUT_LANES = TGC_LANES,
  parameter int DW        = TGC_DW,
  parameter int AW        = TGC_AW,
  parameter int LOG_INP   = 4,
  parameter int LOG_WGT   = 4,
  parameter int LOG_ACC   = 4,
  parameter int CW        = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           act_wr_en,
  input  logic [LOG_INP-1:0]             act_wr_idx,
  input  logic [IN_LANES*DW-1:0]         act_wr_data,
  input  logic                           wgt_wr_en,
  input  logic [LOG_WGT-1:0]             wgt_wr_idx,
  input  logic [OUT_LANES*IN_LANES*DW-1:0] wgt_wr_data,
  input  logic                           cmd_valid,
  input  logic                           cmd_zero,
  input  logic [LOG_ACC-1:0]             cmd_acc_idx,
  input  logic [LOG_INP-1:0]             cmd_act_idx,
  input  logic [LOG_WGT-1:0]             cmd_wgt_idx,
  input  logic                           st_valid,
  input  logic [LOG_ACC-1:0]             st_acc_idx,
  output logic                           st_out_valid,
  output logic [OUT_LANES*DW-1:0]        st_out_data,
  output logic [CW-1:0]                  op_count
);
  localparam int ACT_W = IN_LANES * DW;
  localparam int WGT_W = OUT_LANES * IN_LANES * DW;
  localparam int ROW_W = OUT_LANES * AW;
  localparam int OUT_W = OUT_LANES * DW;

  // Lane-wise helpers
  function automatic logic [ROW_W-1:0] row_add(
    input logic [ROW_W-1:0] a,
    input logic [ROW_W-1:0] b
  );
    logic [ROW_W-1:0] r;
    for (int j = 0; j < OUT_LANES; j++)
      r[j*AW +: AW] = a[j*AW +: AW] + b[j*AW +: AW];
    return r;
  endfunction

  function automatic logic [OUT_W-1:0] narrow_row(input logic [ROW_W-1:0] a);
    logic [OUT_W-1:0] r;
    for (int j = 0; j < OUT_LANES; j++)
      r[j*DW +: DW] = a[j*AW +: DW];
    return r;
  endfunction

  // Operand buffers
  logic [ACT_W-1:0] act_rd;
  logic [WGT_W-1:0] wgt_rd;
  logic [ROW_W-1:0] dot_vec;

  tgc_tile_buf #(.DEPTH_LOG(LOG_INP), .WIDTH(ACT_W)) u_act_buf (
    .clk(clk), .we(act_wr_en), .waddr(act_wr_idx), .wdata(act_wr_data),
    .raddr(cmd_act_idx), .rdata(act_rd)
  );

  tgc_tile_buf #(.DEPTH_LOG(LOG_WGT), .WIDTH(WGT_W)) u_wgt_buf (
    .clk(clk), .we(wgt_wr_en), .waddr(wgt_wr_idx), .wdata(wgt_wr_data),
    .raddr(cmd_wgt_idx), .rdata(wgt_rd)
  );

  tgc_mac_array #(.IN_LANES(IN_LANES), .OUT_LANES(OUT_LANES), .DW(DW), .AW(AW)) u_mac (
    .act(act_rd), .wgt(wgt_rd), .dot(dot_vec)
  );

  // Accumulator file and write-back stage
  logic [ROW_W-1:0]   acc_rd_cmd;
  logic [ROW_W-1:0]   acc_rd_st;
  s1_op_e             s1_op;
  logic [LOG_ACC-1:0] s1_idx;
  logic [ROW_W-1:0]   s1_prior;
  logic [ROW_W-1:0]   s1_dot;

  // Named write-port events, observed by the checker
  logic               wr_en;
  logic [LOG_ACC-1:0] wr_idx;
  logic [ROW_W-1:0]   wr_data;

  assign wr_en   = (s1_op != S1_IDLE);
  assign wr_idx  = s1_idx;
  assign wr_data = (s1_op == S1_ZERO) ? '0 : row_add(s1_prior, s1_dot);

  tgc_acc_file #(.ACC_LOG(LOG_ACC), .ROW_W(ROW_W)) u_acc (
    .clk(clk), .we(wr_en), .widx(wr_idx), .wdata(wr_data),
    .ridx_a(cmd_acc_idx), .rdata_a(acc_rd_cmd),
    .ridx_b(st_acc_idx), .rdata_b(acc_rd_st)
  );

  // Forwarding of the in-flight row to both readers
  logic fwd_cmd_hit;
  logic fwd_st_hit;
  logic [ROW_W-1:0] cmd_prior;
  logic [ROW_W-1:0] st_row;

  assign fwd_cmd_hit = wr_en && (wr_idx == cmd_acc_idx);
  assign fwd_st_hit  = wr_en && (wr_idx == st_acc_idx);
  assign cmd_prior   = fwd_cmd_hit ? wr_data : acc_rd_cmd;
  assign st_row      = fwd_st_hit  ? wr_data : acc_rd_st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_op    <= S1_IDLE;
      s1_idx   <= '0;
      s1_prior <= '0;
      s1_dot   <= '0;
    end else begin
      if (!cmd_valid)     s1_op <= S1_IDLE;
      else if (cmd_zero)  s1_op <= S1_ZERO;
      else                s1_op <= S1_MAC;
      s1_idx   <= cmd_acc_idx;
      s1_prior <= cmd_prior;
      s1_dot   <= dot_vec;
    end
  end

  // Narrowing store
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_out_valid <= 1'b0;
      st_out_data  <= '0;
    end else begin
      st_out_valid <= st_valid;
      if (st_valid) st_out_data <= narrow_row(st_row);
    end
  end

  // Operation counter
  always_ff @(posedge clk) begin
    if (!rst_n)                      op_count <= '0;
    else if (cmd_valid && !cmd_zero) op_count <= op_count + 1'b1;
  end
endmodule

// File: rtl/tgc_checker.sv
module tgc_checker #(
  parameter int ACC_LOG = 4,
  parameter int ROW_W   = 512,
  parameter int CW      = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               cmd_zero,
  input logic [ACC_LOG-1:0] cmd_acc_idx,
  input logic               st_valid,
  input logic               st_out_valid,
  input logic [CW-1:0]      op_count,
  input logic               wr_en,
  input logic [ACC_LOG-1:0] wr_idx,
  input logic [ROW_W-1:0]   wr_data
);
  // R7: counter steps on each accumulate command
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_zero) |=> op_count == $past(op_count) + 1'b1);

  // R7: counter holds otherwise
  a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && !cmd_zero) |=> $stable(op_count));

  // R5: store answers one cycle later
  a_r5_store_valid: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |=> st_out_valid);

  a_r5_store_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !st_valid |=> !st_out_valid);

  // R6: every accepted command reaches the write port with its row
  a_r6_write_slot: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (wr_en && wr_idx == $past(cmd_acc_idx)));

  a_r6_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !wr_en);

  // R3: a zeroing command writes an all-zero row
  a_r3_zero_row: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_zero) |=> (wr_data == '0));
endmodule

bind tile_gemm_core tgc_checker #(
  .ACC_LOG(LOG_ACC), .ROW_W(ROW_W), .CW(CW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_zero(cmd_zero),
  .cmd_acc_idx(cmd_acc_idx), .st_valid(st_valid), .st_out_valid(st_out_valid),
  .op_count(op_count), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
);

// File: tb/tile_gemm_core_tb_top.sv
module tile_gemm_core_tb_top;
  localparam int IL = 16;
  localparam int OL = 16;
  localparam int DW = 8;
  localparam int LI = 4;
  localparam int LW = 4;
  localparam int LA = 4;
  localparam int CW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic act_wr_en = 1'b0;
  logic [LI-1:0] act_wr_idx = '0;
  logic [IL*DW-1:0] act_wr_data = '0;
  logic wgt_wr_en = 1'b0;
  logic [LW-1:0] wgt_wr_idx = '0;
  logic [OL*IL*DW-1:0] wgt_wr_data = '0;
  logic cmd_valid = 1'b0;
  logic cmd_zero = 1'b0;
  logic [LA-1:0] cmd_acc_idx = '0;
  logic [LI-1:0] cmd_act_idx = '0;
  logic [LW-1:0] cmd_wgt_idx = '0;
  logic st_valid = 1'b0;
  logic [LA-1:0] st_acc_idx = '0;
  logic st_out_valid;
  logic [OL*DW-1:0] st_out_data;
  logic [CW-1:0] op_count;

  always #4 clk = ~clk;

  tile_gemm_core dut_i (.*);

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int act_m [16][IL];
  int wgt_m [16][OL][IL];
  longint acc_m [16][OL];
  longint exp_count = 0;

  function automatic logic [7:0] low8(longint v);
    longint r;
    r = v % 256;
    if (r < 0) r += 256;
    return 8'(r);
  endfunction

  task automatic check(bit ok, string req, string what, longint act_v, longint exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act_v, exp_v);
    end
  endtask

  task automatic put_act(int t);
    act_wr_en = 1; act_wr_idx = LI'(t);
    for (int k = 0; k < IL; k++) act_wr_data[k*DW +: DW] = 8'(act_m[t][k]);
    @(negedge clk);
    act_wr_en = 0;
  endtask

  task automatic put_wgt(int t);
    wgt_wr_en = 1; wgt_wr_idx = LW'(t);
    for (int j = 0; j < OL; j++)
      for (int k = 0; k < IL; k++)
        wgt_wr_data[(j*IL+k)*DW +: DW] = 8'(wgt_m[t][j][k]);
    @(negedge clk);
    wgt_wr_en = 0;
  endtask

  task automatic issue(int a, int i, int w, bit z);
    cmd_valid = 1; cmd_zero = z;
    cmd_acc_idx = LA'(a); cmd_act_idx = LI'(i); cmd_wgt_idx = LW'(w);
    if (z) begin
      for (int j = 0; j < OL; j++) acc_m[a][j] = 0;
    end else begin
      exp_count++;
      for (int j = 0; j < OL; j++) begin
        longint s = 0;
        for (int k = 0; k < IL; k++) s += longint'(act_m[i][k]) * longint'(wgt_m[w][j][k]);
        acc_m[a][j] += s;
      end
    end
    @(negedge clk);
    cmd_valid = 0; cmd_zero = 0;
  endtask

  task automatic check_row(int a, string req);
    bit ok = 1;
    int bad = 0;
    st_valid = 1; st_acc_idx = LA'(a);
    @(negedge clk);
    st_valid = 0;
    check(st_out_valid === 1'b1, req, "store valid", longint'(st_out_valid), 1);
    for (int j = 0; j < OL; j++)
      if (st_out_data[j*DW +: DW] !== low8(acc_m[a][j])) begin ok = 0; bad = j; end
    check(ok, req, $sformatf("row %0d lane %0d", a, bad),
          longint'(st_out_data[bad*DW +: DW]), longint'(low8(acc_m[a][bad])));
  endtask

  task automatic check_count(string req);
    check(op_count == CW'(exp_count), req, "op_count", longint'(op_count), exp_count);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < 16; t++)
      for (int k = 0; k < IL; k++) act_m[t][k] = ((t*37 + k*13 + 5) % 256) - 128;
    for (int t = 0; t < 16; t++)
      for (int j = 0; j < OL; j++)
        for (int k = 0; k < IL; k++) wgt_m[t][j][k] = ((t*29 + j*7 + k*3 + 1) % 256) - 128;

    repeat (3) @(negedge clk);
    // R8: reset state
    check(op_count == 0, "R8", "count after reset", longint'(op_count), 0);
    check(st_out_valid == 1'b0, "R8", "store valid after reset", longint'(st_out_valid), 0);
    rst_n = 1;
    @(negedge clk);

    for (int t = 0; t < 16; t++) begin put_act(t); put_wgt(t); end

    // R1 R6: zero then accumulate same row back-to-back, store next cycle (R5)
    issue(0, 0, 0, 1);
    issue(0, 3, 5, 0);
    check_row(0, "R1");
    check_count("R7");

    // R9 R2: 4x4 tiled problem, input-channel loop outermost
    for (int co = 0; co < 4; co++) issue(1 + co, 0, 0, 1);
    for (int ko = 0; ko < 4; ko++)
      for (int co = 0; co < 4; co++) issue(1 + co, ko, co*4 + ko, 0);
    for (int co = 0; co < 4; co++) check_row(1 + co, "R9");
    check(exp_count == 17 && op_count == 17, "R9", "tile op count", longint'(op_count), 17);
    check_row(0, "R2");

    // R6: five back-to-back accumulates on one row
    issue(7, 0, 0, 1);
    for (int n = 0; n < 5; n++) issue(7, n + 6, 11 - n, 0);
    check_row(7, "R6");
    // R2: accumulate again after a gap, then R5 store directly after one command
    issue(7, 2, 2, 0);
    check_row(7, "R2");

    // R3: zero a populated row; not counted
    issue(7, 0, 0, 1);
    check_row(7, "R3");
    check_count("R3");

    // R4: wrap instead of saturation
    for (int k = 0; k < IL; k++) act_m[15][k] = 1;
    for (int j = 0; j < OL; j++)
      for (int k = 0; k < IL; k++) begin wgt_m[15][j][k] = 127; wgt_m[14][j][k] = -3; end
    put_act(15); put_wgt(15); put_wgt(14);
    issue(9, 0, 0, 1);
    issue(9, 15, 15, 0);
    check_row(9, "R4");
    check(st_out_data[7:0] == 8'hF0, "R4", "wrap 2032", longint'(st_out_data[7:0]), 240);
    issue(10, 0, 0, 1);
    issue(10, 15, 14, 0);
    check_row(10, "R4");
    check(st_out_data[7:0] == 8'hD0, "R4", "wrap -48", longint'(st_out_data[7:0]), 208);

    // R1: every lane sweep of tile pairs into scratch row 11
    for (int p = 0; p < 8; p++) begin
      issue(11, 0, 0, 1);
      issue(11, p, 15 - p - 2 < 0 ? 0 : 13 - p, 0);
      check_row(11, "R1");
    end
    check_count("R7");

    // R7 R8: synchronous reset clears counter
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    exp_count = 0;
    check_count("R7");
    check(st_out_valid == 1'b0, "R8", "store valid after reset", longint'(st_out_valid), 0);
    rst_n = 1;
    @(negedge clk);
    issue(12, 1, 1, 1);
    issue(12, 1, 1, 0);
    check_count("R7");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule